// File: doc/BRIEF.md
# DSP-Mode Serial Audio Port

The port is the framing and shifting stage of a master-mode serial audio link. A clock generator outside the block supplies three timing inputs. `bit_launch` is a one-cycle strobe on the edge where transmit data changes. `bit_sample` is a one-cycle strobe on the opposite edge, where receive data is captured. `fsync` is a level that is high for exactly one bit slot per frame. The port carries one 16-bit word, MSB first, in each direction per frame. It pops transmit words from a show-ahead FIFO and pushes assembled receive words into a receive FIFO.

Software-style commands start or stop each direction. They maintain a five-bit control word whose bit positions are fixed because neighbouring logic decodes them:

- bit 0: global enable
- bit 1: receive enable
- bit 2: transmit enable
- bit 3: receive MSB-after-sync
- bit 4: transmit MSB-after-sync

Each direction chooses on its own whether its MSB shares the sync slot or follows it by one bit slot. Slots beyond the word are driven low on transmit and ignored on receive.

A missing transmit word is replaced by zeros and flagged as a starve event. A receive word that finds the FIFO full is discarded and flagged as an overflow.

Top module: `sap_dsp_port`

## Requirements
- R1: A start command (`cmd_on`=1) for a direction sets that direction's enable bit (bit 2 for transmit, bit 1 for receive) and the global enable bit 0 of `ctrl_o`, one cycle after the command strobe. A format strobe writes bit 4 from `fmt_tx_late` and bit 3 from `fmt_rx_late`.
- R2: A stop command clears that direction's enable bit. Bit 0 is cleared as well only when the other direction's enable bit is already clear; otherwise it stays set.
- R3: After reset `ctrl_o` is 0, `sdo` is low, and `tx_pop`, `tx_starve`, `rx_push` and `rx_ovf` are low.
- R4: With bit 4 clear, the transmit word's bit 15 appears on `sdo` in the sync slot, and bits 14..0 follow in the next 15 slots, one bit per `bit_launch`.
- R5: With bit 4 set, `sdo` is low in the sync slot, and bits 15..0 occupy the 16 slots after it.
- R6: With bit 3 clear, receive bits 15..0 are sampled from `sdi` at `bit_sample` in the sync slot and the 15 slots after it. With bit 3 set, they are sampled in the 16 slots after the sync slot. The word is pushed on `rx_data` with a one-cycle `rx_push` one cycle after the last sample strobe, once per frame.
- R7: `tx_pop` pulses for one cycle exactly once per frame, at the `bit_launch` of the sync slot, when transmit is active (bits 0 and 2 set) and `tx_empty` is low.
- R8: If `tx_empty` is high at the sync-slot launch of an active transmitter, the port shifts an all-zero word, pulses `tx_starve` for that cycle, and does not pop.
- R9: If `rx_full` is high in the cycle of the final sample of an active receiver, the word is dropped: `rx_ovf` pulses instead of `rx_push`.
- R10: Transmit slots after the 16 word slots are low, and `sdi` values outside the 16 word slots do not affect the pushed word.
- R11: An inactive transmitter drives `sdo` low and never pops or starves. An inactive receiver never pushes or overflows.
- R12: `sdo` changes only in the cycle after a `bit_launch` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_stb | input | 1 | Start/stop command strobe |
| cmd_tx | input | 1 | Command target: 1 transmit, 0 receive |
| cmd_on | input | 1 | 1 start, 0 stop |
| fmt_stb | input | 1 | Format write strobe |
| fmt_tx_late | input | 1 | Transmit MSB one slot after sync |
| fmt_rx_late | input | 1 | Receive MSB one slot after sync |
| bit_launch | input | 1 | Transmit-edge strobe from the clock generator |
| bit_sample | input | 1 | Receive-edge strobe from the clock generator |
| fsync | input | 1 | Frame sync, high for one bit slot |
| sdo | output | 1 | Serial transmit data |
| sdi | input | 1 | Serial receive data |
| tx_pop | output | 1 | Transmit FIFO pop |
| tx_data | input | WORD_W | Transmit FIFO head word |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_starve | output | 1 | Transmit starve event |
| rx_push | output | 1 | Receive FIFO push |
| rx_data | output | WORD_W | Receive word |
| rx_full | input | 1 | Receive FIFO full |
| rx_ovf | output | 1 | Receive overflow event |
| ctrl_o | output | 5 | Control word |

## Verification
The assertions assume that the clock generator never raises `bit_launch` and `bit_sample` in the same cycle. They also assume that `fsync` changes only together with a launch strobe and stays high across the whole sync slot. The starve and overflow properties further assume that `tx_empty` and `rx_full` hold steady for at least a cycle around the strobes that read them.

The bench models the clock generator itself, so these assumptions hold throughout the run. Each bit slot is four clocks long: launch at the first, sample at the third, and `fsync` held for the whole first slot of a 20-slot frame. The FIFO flags are held constant for each whole frame.

// File: rtl/sap_pkg.sv
// sap_pkg: shared control-word layout for the serial audio port.
// Assumes: bit positions are fixed because neighbouring logic decodes them.
package sap_pkg;
    localparam int CTL_W = 5;

    // Packed from bit 4 down to bit 0.
    typedef struct packed {
        logic tx_late;  // bit 4
        logic rx_late;  // bit 3
        logic tx_en;    // bit 2
        logic rx_en;    // bit 1
        logic glb_en;   // bit 0
    } sap_ctl_t;
endpackage

// File: rtl/sap_ctl.sv
// sap_ctl: holds the control word and applies start/stop and format commands.
// Assumes: a command and a format write in the same cycle touch disjoint fields.
module sap_ctl
    import sap_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_stb,
    input  logic     cmd_tx,
    input  logic     cmd_on,
    input  logic     fmt_stb,
    input  logic     fmt_tx_late,
    input  logic     fmt_rx_late,
    output sap_ctl_t ctl_q
);
    sap_ctl_t ctl_d;

    // Next-state: start sets direction and global; stop drops global only if the other side is off.
    always_comb begin
        ctl_d = ctl_q;
        if (cmd_stb) begin
            if (cmd_on) begin
                if (cmd_tx) ctl_d.tx_en = 1'b1;
                else        ctl_d.rx_en = 1'b1;
                ctl_d.glb_en = 1'b1;
            end else if (cmd_tx) begin
                ctl_d.tx_en = 1'b0;
                if (!ctl_q.rx_en) ctl_d.glb_en = 1'b0;
            end else begin
                ctl_d.rx_en = 1'b0;
                if (!ctl_q.tx_en) ctl_d.glb_en = 1'b0;
            end
        end
        if (fmt_stb) begin
            ctl_d.tx_late = fmt_tx_late;
            ctl_d.rx_late = fmt_rx_late;
        end
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end
endmodule

// File: rtl/sap_tx.sv
// sap_tx: transmit shifter; loads one word per frame at the sync-slot launch edge.
// Assumes: tx_data is valid whenever tx_empty is low (show-ahead FIFO).
module sap_tx #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_launch,
    input  logic              fsync,
    input  logic              active,
    input  logic              late,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              tx_starve,
    output logic              sdo
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] sh_q;
    logic [CNT_W-1:0]  left_q;
    logic              word_start;
    logic [WORD_W-1:0] load_w;

    // Word start decode and FIFO handshake (pop or starve).
    always_comb begin
        word_start = bit_launch && fsync && active;
        tx_pop     = word_start && !tx_empty;
        tx_starve  = word_start && tx_empty;
        load_w     = tx_empty ? '0 : tx_data;
    end

    // Shift state: updates only on launch strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo    <= 1'b0;
            sh_q   <= '0;
            left_q <= '0;
        end else if (bit_launch) begin
            if (!active) begin
                sdo    <= 1'b0;
                left_q <= '0;
            end else if (fsync) begin
                if (late) begin
                    sdo    <= 1'b0;
                    sh_q   <= load_w;
                    left_q <= CNT_W'(WORD_W);
                end else begin
                    sdo    <= load_w[WORD_W-1];
                    sh_q   <= {load_w[WORD_W-2:0], 1'b0};
                    left_q <= CNT_W'(WORD_W - 1);
                end
            end else if (left_q != '0) begin
                sdo    <= sh_q[WORD_W-1];
                sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
                left_q <= left_q - 1'b1;
            end else begin
                sdo <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sap_rx.sv
// sap_rx: receive shifter; assembles one word per frame from sample-edge bits.
// Assumes: fsync is high across the whole sync slot, so a sample strobe sees it.
module sap_rx #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_sample,
    input  logic              fsync,
    input  logic              active,
    input  logic              late,
    input  logic              sdi,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_ovf
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] sh_q;
    logic [CNT_W-1:0]  left_q;
    logic [WORD_W-1:0] sh_next;

    // Next shift value with the current serial bit.
    always_comb sh_next = {sh_q[WORD_W-2:0], sdi};

    // Capture state and one-cycle push/overflow pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            left_q  <= '0;
            rx_push <= 1'b0;
            rx_ovf  <= 1'b0;
            rx_data <= '0;
        end else begin
            rx_push <= 1'b0;
            rx_ovf  <= 1'b0;
            if (bit_sample) begin
                if (!active) begin
                    left_q <= '0;
                end else if (fsync) begin
                    if (late) begin
                        sh_q   <= '0;
                        left_q <= CNT_W'(WORD_W);
                    end else begin
                        sh_q   <= {{(WORD_W-1){1'b0}}, sdi};
                        left_q <= CNT_W'(WORD_W - 1);
                    end
                end else if (left_q != '0) begin
                    sh_q   <= sh_next;
                    left_q <= left_q - 1'b1;
                    if (left_q == CNT_W'(1)) begin
                        if (rx_full) begin
                            rx_ovf <= 1'b1;
                        end else begin
                            rx_push <= 1'b1;
                            rx_data <= sh_next;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sap_dsp_port.sv
// sap_dsp_port: master-mode DSP-format serial audio port, one word each way per frame.
// Assumes: timing strobes come from an external clock generator in the clk domain.
module sap_dsp_port
    import sap_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_stb,
    input  logic              cmd_tx,
    input  logic              cmd_on,
    input  logic              fmt_stb,
    input  logic              fmt_tx_late,
    input  logic              fmt_rx_late,
    input  logic              bit_launch,
    input  logic              bit_sample,
    input  logic              fsync,
    output logic              sdo,
    input  logic              sdi,
    output logic              tx_pop,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_empty,
    output logic              tx_starve,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_data,
    input  logic              rx_full,
    output logic              rx_ovf,
    output logic [CTL_W-1:0]  ctrl_o
);
    sap_ctl_t ctl;
    logic     tx_act;
    logic     rx_act;

    // Per-direction activity gated by the global enable.
    always_comb begin
        tx_act = ctl.glb_en && ctl.tx_en;
        rx_act = ctl.glb_en && ctl.rx_en;
        ctrl_o = ctl;
    end

    sap_ctl u_ctl (
        .clk(clk), .rst_n(rst_n),
        .cmd_stb(cmd_stb), .cmd_tx(cmd_tx), .cmd_on(cmd_on),
        .fmt_stb(fmt_stb), .fmt_tx_late(fmt_tx_late), .fmt_rx_late(fmt_rx_late),
        .ctl_q(ctl)
    );

    sap_tx #(.WORD_W(WORD_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .bit_launch(bit_launch), .fsync(fsync),
        .active(tx_act), .late(ctl.tx_late), .tx_empty(tx_empty),
        .tx_data(tx_data), .tx_pop(tx_pop), .tx_starve(tx_starve), .sdo(sdo)
    );

    sap_rx #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .bit_sample(bit_sample), .fsync(fsync),
        .active(rx_act), .late(ctl.rx_late), .sdi(sdi), .rx_full(rx_full),
        .rx_push(rx_push), .rx_data(rx_data), .rx_ovf(rx_ovf)
    );
endmodule

// File: rtl/sap_dsp_port_chk.sv
// sap_dsp_port_chk: protocol properties of the port, bound to the top module.
// Assumes: launch and sample strobes never coincide.
module sap_dsp_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_launch,
    input logic       sdo,
    input logic       tx_pop,
    input logic       tx_empty,
    input logic       tx_starve,
    input logic       rx_push,
    input logic       rx_full,
    input logic       rx_ovf,
    input logic [4:0] ctrl_o
);
    // Global enable stays on while either direction is on.
    p_global_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[2] || ctrl_o[1]) |-> ctrl_o[0]);

    // A pop never happens from an empty FIFO, and only on a launch strobe.
    p_pop_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (!tx_empty && bit_launch));

    // Starve only with an empty FIFO, never together with a pop.
    p_starve_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_starve |-> (tx_empty && !tx_pop));

    // Overflow follows a full FIFO and excludes a push.
    p_no_push_on_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf |-> (!rx_push && $past(rx_full)));

    // A push only happens when the FIFO had room.
    p_push_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !$past(rx_full));

    // An inactive transmitter drives low after a launch.
    p_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_launch && !(ctrl_o[2] && ctrl_o[0])) |=> !sdo);

    // Serial output moves only after launch strobes.
    p_sdo_launch_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_launch |=> $stable(sdo));
endmodule

bind sap_dsp_port sap_dsp_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bit_launch(bit_launch), .sdo(sdo),
    .tx_pop(tx_pop), .tx_empty(tx_empty), .tx_starve(tx_starve),
    .rx_push(rx_push), .rx_full(rx_full), .rx_ovf(rx_ovf), .ctrl_o(ctrl_o)
);

// File: tb/sap_dsp_port_bench.sv
`timescale 1ns/100ps
// sap_dsp_port_bench: sweeps formats, words and FIFO conditions frame by frame.
module sap_dsp_port_bench;
    localparam int W     = 16;
    localparam int FRAME = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_stb = 0, cmd_tx = 0, cmd_on = 0;
    logic fmt_stb = 0, fmt_tx_late = 0, fmt_rx_late = 0;
    logic bit_launch = 0, bit_sample = 0, fsync = 0, sdi = 0;
    logic [W-1:0] tx_data = '0;
    logic tx_empty = 1'b1, rx_full = 1'b0;
    logic sdo, tx_pop, tx_starve, rx_push, rx_ovf;
    logic [W-1:0] rx_data;
    logic [4:0] ctrl_o;

    int n_vec = 0, n_bad = 0;
    int n_pop, n_starve, n_push, n_ovf;
    logic [W-1:0] last_rx;
    logic monitor_on = 1'b0;

    always #2.5 clk = ~clk;

    sap_dsp_port #(.WORD_W(W)) u_sap_dsp_port (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_tx(cmd_tx), .cmd_on(cmd_on),
        .fmt_stb(fmt_stb), .fmt_tx_late(fmt_tx_late), .fmt_rx_late(fmt_rx_late),
        .bit_launch(bit_launch), .bit_sample(bit_sample), .fsync(fsync),
        .sdo(sdo), .sdi(sdi), .tx_pop(tx_pop), .tx_data(tx_data), .tx_empty(tx_empty),
        .tx_starve(tx_starve), .rx_push(rx_push), .rx_data(rx_data), .rx_full(rx_full),
        .rx_ovf(rx_ovf), .ctrl_o(ctrl_o)
    );

    // Event counters sampled mid-cycle, once per clock.
    always begin
        @(negedge clk); #1;
        if (monitor_on) begin
            if (tx_pop)    n_pop++;
            if (tx_starve) n_starve++;
            if (rx_ovf)    n_ovf++;
            if (rx_push) begin n_push++; last_rx = rx_data; end
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    // Bit carried in slot s, or -1 when the slot is outside the word.
    function automatic int slot_bit(input logic late, input int s);
        if (!late) return (s < W) ? (W - 1 - s) : -1;
        return (s >= 1 && s <= W) ? (W - s) : -1;
    endfunction

    function automatic logic [W-1:0] word_of(input int k);
        case (k)
            0: return 16'h8001;
            1: return 16'h7FFE;
            2: return 16'hFFFF;
            3: return 16'h0000;
            default: return 16'(16'hA5C3 ^ (k * 16'h1357));
        endcase
    endfunction

    task automatic cmd(input logic tx, input logic on);
        @(negedge clk); cmd_stb = 1; cmd_tx = tx; cmd_on = on;
        @(negedge clk); cmd_stb = 0; #1;
    endtask

    task automatic fmt(input logic tl, input logic rl);
        @(negedge clk); fmt_stb = 1; fmt_tx_late = tl; fmt_rx_late = rl;
        @(negedge clk); fmt_stb = 0; #1;
    endtask

    // One frame: drive strobes/sdi, collect sdo, then check against the model.
    task automatic run_frame(input logic [W-1:0] txw, input logic empty,
                             input logic [W-1:0] rxw, input logic full,
                             input logic tx_act, input logic rx_act,
                             input logic tl, input logic rl);
        logic [FRAME-1:0] got_sdo, exp_sdo;
        int b;
        n_pop = 0; n_starve = 0; n_push = 0; n_ovf = 0; last_rx = '0;
        got_sdo = '0; exp_sdo = '0;
        tx_data = txw; tx_empty = empty; rx_full = full;
        monitor_on = 1'b1;
        for (int s = 0; s < FRAME; s++) begin
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                bit_launch = (c == 0);
                bit_sample = (c == 2);
                fsync      = (s == 0);
                if (c == 0) begin
                    b = slot_bit(rl, s);
                    sdi = (b < 0) ? 1'b1 : rxw[b];
                end
                #1;
                if (c == 2) got_sdo[s] = sdo;
            end
        end
        @(negedge clk); bit_launch = 0; bit_sample = 0; fsync = 0;
        #2; monitor_on = 1'b0;
        for (int s = 0; s < FRAME; s++) begin
            b = slot_bit(tl, s);
            exp_sdo[s] = (tx_act && !empty && b >= 0) ? txw[b] : 1'b0;
        end
        chk(tl ? "R5/R10/R11 sdo slots" : "R4/R10/R11 sdo slots", 32'(got_sdo), 32'(exp_sdo));
        chk("R7 pop count", 32'(n_pop), 32'(tx_act && !empty));
        chk("R8 starve count", 32'(n_starve), 32'(tx_act && empty));
        chk("R6/R11 push count", 32'(n_push), 32'(rx_act && !full));
        chk("R9 overflow count", 32'(n_ovf), 32'(rx_act && full));
        if (rx_act && !full) chk("R6/R10 rx word", 32'(last_rx), 32'(rxw));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++; n_vec++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R3 reset state
        chk("R3 ctrl", 32'(ctrl_o), 32'h0);
        chk("R3 outputs", 32'({sdo, tx_pop, tx_starve, rx_push, rx_ovf}), 32'h0);

        // R1 / R2 command sequencing
        cmd(1, 1); chk("R1 tx start", 32'(ctrl_o), 32'h05);
        cmd(0, 1); chk("R1 rx start", 32'(ctrl_o), 32'h07);
        cmd(1, 0); chk("R2 tx stop keeps global", 32'(ctrl_o), 32'h03);
        cmd(0, 0); chk("R2 last stop clears global", 32'(ctrl_o), 32'h00);
        cmd(0, 1); cmd(1, 0); chk("R2 stop of idle tx", 32'(ctrl_o), 32'h03);
        cmd(0, 0); chk("R2 rx stop", 32'(ctrl_o), 32'h00);
        fmt(1, 1); chk("R1 format bits", 32'(ctrl_o), 32'h18);

        // R11 fully inactive frame with junk present
        run_frame(16'h1234, 1'b0, 16'hBEEF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);

        // Main sweep: every format pair, several word patterns, both directions on
        cmd(1, 1); cmd(0, 1);
        for (int m = 0; m < 4; m++) begin
            fmt(m[1], m[0]);
            chk("R1 format write", 32'(ctrl_o), 32'({m[1], m[0], 3'b111}));
            for (int k = 0; k < 6; k++)
                run_frame(word_of(k), 1'b0, ~word_of(k + 2), 1'b0,
                          1'b1, 1'b1, m[1], m[0]);
        end

        // R8 starve and R9 overflow, both formats
        for (int m = 0; m < 2; m++) begin
            fmt(m[0], m[0]);
            run_frame(16'hFFFF, 1'b1, 16'h5A5A, 1'b1, 1'b1, 1'b1, m[0], m[0]);
        end

        // R11 transmit only: receiver must stay silent
        cmd(0, 0); fmt(0, 0);
        run_frame(16'hC0DE, 1'b0, 16'h3333, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        // R11 receive only: transmitter low, no pop
        cmd(0, 1); cmd(1, 0);
        run_frame(16'hC0DE, 1'b0, 16'h9669, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule